// File: doc/BRIEF.md
# Synchronous True Dual-Port RAM with Burst Address Counters

The block is a word-addressed storage array that two independent agents reach through two identical ports. Each port runs on its own clock and registers its address, write data and controls on the rising edge. The data word is 9 bits wide by default. The depth is 2^AW words; the default AW of 8 keeps elaboration small, and AW = 14 gives 16K words. Either port may read or write any word at any time, including the word the other port is using. Collisions are neither arbitrated nor flagged.

Each port takes its address from a burst counter. In any cycle the counter can be cleared, loaded from the external address, advanced by one, or held, and the access in that cycle uses the new value. Read data leaves on a plain data bus together with a drive-enable flag, which stands in for a tri-state pin. Two inputs act on that flag without a clock: a per-port output enable, and a per-port static latency select that chooses between flow-through output and pipelined output.

The drive-enable flag is decided by the controls of earlier cycles. In flow-through mode it follows the read of the previous edge. In pipelined mode the data is one clock older, and the port must have been selected at both of the last two edges.

Top module: `tdp_sync_ram`

## Requirements
- R1: A port is selected at an edge only when its `CsN` input is 0 and its `Cs` input is 1. At an edge where it is not selected, it neither writes nor reads, and `DoutEn` is 0 for the whole following cycle.
- R2: A selected edge with `RdWrN` = 0 stores `Din` at that edge's access address. In flow-through mode, `DoutEn` is 0 in the following cycle.
- R3: `OeN` = 1 forces `DoutEn` to 0 at once, with no clock edge. Returning `OeN` to 0 restores the state that the registered controls call for.
- R4: With `Pipe` = 0 (flow-through), a selected edge with `RdWrN` = 1 makes `DoutEn` 1 and puts the addressed word on `Dout` for the cycle that follows that edge.
- R5: With `Pipe` = 1 (pipelined), the word read at edge k appears on `Dout` in the cycle that follows edge k+1. `Pipe` is sampled without a clock, and each port has its own `Pipe` input.
- R6: In pipelined mode, `DoutEn` is 1 in the cycle after edge k+1 only when edge k was a selected read and the port was also selected at edge k+1. After a deselect at edge k, `DoutEn` stays 0 through the cycle after edge k+1.
- R7: The access address at an edge is chosen by priority: 0 when `ClrN` = 0; otherwise `Addr` when `AdrLdN` = 0; otherwise the previous address plus one when `AdvN` = 0; otherwise the previous address. The counter updates whether or not the port is selected.
- R8: After one port writes a word, a read of that word on the other port at the reader's first edge strictly later than the write edge returns the new data. Both ports may read the same word at the same time.
- R9: While `rstN` = 0, both ports hold `DoutEn` at 0 and both counters at 0. After release, a hold access (`ClrN`, `AdrLdN`, `AdvN` all 1) reaches word 0.
- R10: Advancing the counter from 2^AW-1 wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset for both ports |
| aClk | input | 1 | Port A clock |
| aCsN | input | 1 | Port A active-low chip select |
| aCs | input | 1 | Port A active-high chip select |
| aRdWrN | input | 1 | Port A: 1 = read, 0 = write |
| aOeN | input | 1 | Port A asynchronous active-low output enable |
| aPipe | input | 1 | Port A latency select: 1 = pipelined, 0 = flow-through |
| aAdrLdN | input | 1 | Port A active-low load of the external address |
| aAdvN | input | 1 | Port A active-low counter advance |
| aClrN | input | 1 | Port A active-low counter clear |
| aAddr | input | AW | Port A external address |
| aDin | input | DW | Port A write data |
| aDout | output | DW | Port A read data |
| aDoutEn | output | 1 | Port A drive enable for `aDout` |
| bClk | input | 1 | Port B clock |
| bCsN | input | 1 | Port B active-low chip select |
| bCs | input | 1 | Port B active-high chip select |
| bRdWrN | input | 1 | Port B: 1 = read, 0 = write |
| bOeN | input | 1 | Port B asynchronous active-low output enable |
| bPipe | input | 1 | Port B latency select: 1 = pipelined, 0 = flow-through |
| bAdrLdN | input | 1 | Port B active-low load of the external address |
| bAdvN | input | 1 | Port B active-low counter advance |
| bClrN | input | 1 | Port B active-low counter clear |
| bAddr | input | AW | Port B external address |
| bDin | input | DW | Port B write data |
| bDout | output | DW | Port B read data |
| bDoutEn | output | 1 | Port B drive enable for `bDout` |

## Verification
The two ports can act on the same word within one cycle: one port writes it while the other reads it. The bench runs the port B clock 3 ns behind port A, so every B edge falls inside an A cycle. Directed steps and random traffic then make one port write a word that the other port reads at its next edge. The result is judged against a bench memory model that applies the edges of both ports in true time order. A counter clear that lands on the same edge as a read or write is also provoked. The access is expected to reach word 0 with no lost cycle.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

  // strobes from a port's control to the storage array
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } memStb_t;

  // strobes from a port's control to its output stage
  typedef struct packed {
    logic ftLive;   // read at last edge: flow-through word valid
    logic ppLive;   // read two edges back, selected at last edge
  } outStb_t;

endpackage

// File: rtl/tdp_port_ctrl.sv
module tdp_port_ctrl
  import tdp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          cs,
  input  logic          rdWrN,
  input  logic          adrLdN,
  input  logic          advN,
  input  logic          clrN,
  input  logic [AW-1:0] extAddr,
  output memStb_t       memStb,
  output outStb_t       outStb,
  output logic [AW-1:0] accAddr,
  output logic [AW-1:0] cntQ
);

  logic selNow;
  logic rdVld1;
  logic rdVld2;

  assign selNow = !csN && cs;

  // address source priority: clear, load, advance, hold
  always_comb begin
    if (!clrN)        accAddr = '0;
    else if (!adrLdN) accAddr = extAddr;
    else if (!advN)   accAddr = cntQ + AW'(1);
    else              accAddr = cntQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      rdVld1 <= 1'b0;
      rdVld2 <= 1'b0;
    end else begin
      cntQ   <= accAddr;
      rdVld1 <= selNow && rdWrN;
      rdVld2 <= rdVld1 && selNow;
    end
  end

  assign memStb.wrEn   = selNow && !rdWrN;
  assign memStb.rdEn   = selNow && rdWrN;
  assign outStb.ftLive = rdVld1;
  assign outStb.ppLive = rdVld2;

endmodule

// File: rtl/tdp_store.sv
module tdp_store
  import tdp_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic                 rstN,
  input  logic [1:0]           clk,
  input  memStb_t [1:0]        stb,
  input  logic [1:0][AW-1:0]   addr,
  input  logic [1:0][DW-1:0]   din,
  output logic [1:0][DW-1:0]   rdWord
);

  localparam int DEPTH = 1 << AW;

  // one bank per writing port; a live-value bit pair picks the newer one
  logic [DW-1:0] bankA [DEPTH];
  logic [DW-1:0] bankB [DEPTH];
  logic          liveA [DEPTH];
  logic          liveB [DEPTH];

  function automatic logic [DW-1:0] liveWord(input logic [AW-1:0] a);
    return (liveA[a] ^ liveB[a]) ? bankA[a] : bankB[a];
  endfunction

  always_ff @(posedge clk[0]) begin
    if (stb[0].wrEn) begin
      bankA[addr[0]] <= din[0];
      liveA[addr[0]] <= ~liveB[addr[0]];
    end
  end

  always_ff @(posedge clk[1]) begin
    if (stb[1].wrEn) begin
      bankB[addr[1]] <= din[1];
      liveB[addr[1]] <= liveA[addr[1]];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [DW-1:0] word;
    always_ff @(posedge clk[p] or negedge rstN) begin
      if (!rstN)           word <= '0;
      else if (stb[p].rdEn) word <= liveWord(addr[p]);
    end
    assign rdWord[p] = word;
  end

endmodule

// File: rtl/tdp_port_out.sv
module tdp_port_out
  import tdp_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  outStb_t       stb,
  input  logic [DW-1:0] rdWord,
  input  logic          pipeSel,
  input  logic          oeN,
  output logic [DW-1:0] dout,
  output logic          doutEn
);

  logic [DW-1:0] pipeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pipeQ <= '0;
    else if (stb.ftLive) pipeQ <= rdWord;
  end

  assign dout   = pipeSel ? pipeQ : rdWord;
  assign doutEn = !oeN && (pipeSel ? stb.ppLive : stb.ftLive);

endmodule

// File: rtl/tdp_sync_ram.sv
module tdp_sync_ram
  import tdp_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          rstN,
  input  logic          aClk,
  input  logic          aCsN,
  input  logic          aCs,
  input  logic          aRdWrN,
  input  logic          aOeN,
  input  logic          aPipe,
  input  logic          aAdrLdN,
  input  logic          aAdvN,
  input  logic          aClrN,
  input  logic [AW-1:0] aAddr,
  input  logic [DW-1:0] aDin,
  output logic [DW-1:0] aDout,
  output logic          aDoutEn,
  input  logic          bClk,
  input  logic          bCsN,
  input  logic          bCs,
  input  logic          bRdWrN,
  input  logic          bOeN,
  input  logic          bPipe,
  input  logic          bAdrLdN,
  input  logic          bAdvN,
  input  logic          bClrN,
  input  logic [AW-1:0] bAddr,
  input  logic [DW-1:0] bDin,
  output logic [DW-1:0] bDout,
  output logic          bDoutEn
);

  logic [1:0]         clkV, csNV, csV, rdWrNV, oeNV, pipeV;
  logic [1:0]         adrLdNV, advNV, clrNV, doutEnV;
  logic [1:0][AW-1:0] addrV, accAddr, cntQ;
  logic [1:0][DW-1:0] dinV, rdWord, doutV;
  memStb_t [1:0]      memStb;
  outStb_t [1:0]      outStb;

  assign clkV    = {bClk, aClk};
  assign csNV    = {bCsN, aCsN};
  assign csV     = {bCs, aCs};
  assign rdWrNV  = {bRdWrN, aRdWrN};
  assign oeNV    = {bOeN, aOeN};
  assign pipeV   = {bPipe, aPipe};
  assign adrLdNV = {bAdrLdN, aAdrLdN};
  assign advNV   = {bAdvN, aAdvN};
  assign clrNV   = {bClrN, aClrN};
  assign addrV   = {bAddr, aAddr};
  assign dinV    = {bDin, aDin};

  for (genvar p = 0; p < 2; p++) begin : g_port
    tdp_port_ctrl #(.AW(AW)) u_ctrl (
      .clk    (clkV[p]),
      .rstN   (rstN),
      .csN    (csNV[p]),
      .cs     (csV[p]),
      .rdWrN  (rdWrNV[p]),
      .adrLdN (adrLdNV[p]),
      .advN   (advNV[p]),
      .clrN   (clrNV[p]),
      .extAddr(addrV[p]),
      .memStb (memStb[p]),
      .outStb (outStb[p]),
      .accAddr(accAddr[p]),
      .cntQ   (cntQ[p])
    );

    tdp_port_out #(.DW(DW)) u_out (
      .clk    (clkV[p]),
      .rstN   (rstN),
      .stb    (outStb[p]),
      .rdWord (rdWord[p]),
      .pipeSel(pipeV[p]),
      .oeN    (oeNV[p]),
      .dout   (doutV[p]),
      .doutEn (doutEnV[p])
    );
  end

  tdp_store #(.AW(AW), .DW(DW)) u_store (
    .rstN  (rstN),
    .clk   (clkV),
    .stb   (memStb),
    .addr  (accAddr),
    .din   (dinV),
    .rdWord(rdWord)
  );

  assign aDout   = doutV[0];
  assign bDout   = doutV[1];
  assign aDoutEn = doutEnV[0];
  assign bDoutEn = doutEnV[1];

endmodule

// File: rtl/tdp_sync_ram_chk.sv
module tdp_sync_ram_chk #(
  parameter int AW = 8
) (
  input logic          rstN,
  input logic          aClk,
  input logic          aCsN,
  input logic          aCs,
  input logic          aRdWrN,
  input logic          aOeN,
  input logic          aPipe,
  input logic          aAdrLdN,
  input logic          aAdvN,
  input logic          aClrN,
  input logic [AW-1:0] aAddr,
  input logic          aDoutEn,
  input logic [AW-1:0] cntA,
  input logic          bClk,
  input logic          bCsN,
  input logic          bCs,
  input logic          bOeN,
  input logic          bDoutEn
);

  AST_DESEL_QUIET: assert property (@(posedge aClk) disable iff (!rstN)
    (aCsN || !aCs) |=> !aDoutEn); // R1

  AST_B_DESEL_QUIET: assert property (@(posedge bClk) disable iff (!rstN)
    (bCsN || !bCs) |=> !bDoutEn); // R1

  AST_WRITE_QUIET: assert property (@(posedge aClk) disable iff (!rstN)
    (!aCsN && aCs && !aRdWrN && !aPipe) |=> (aPipe || !aDoutEn)); // R2

  AST_OE_BLOCKS: assert property (@(posedge aClk) disable iff (!rstN)
    aOeN |-> !aDoutEn); // R3

  AST_B_OE_BLOCKS: assert property (@(posedge bClk) disable iff (!rstN)
    bOeN |-> !bDoutEn); // R3

  AST_FT_READ: assert property (@(posedge aClk) disable iff (!rstN)
    (!aCsN && aCs && aRdWrN) |=> (aPipe || aOeN || aDoutEn)); // R4

  AST_PIPE_TWO_SEL: assert property (@(posedge aClk) disable iff (!rstN)
    (!aCsN && aCs && aRdWrN) ##1 (!aCsN && aCs) |=> (!aPipe || aOeN || aDoutEn)); // R6

  AST_PIPE_AFTER_DESEL: assert property (@(posedge aClk) disable iff (!rstN)
    (aCsN || !aCs) |-> ##2 (!aPipe || !aDoutEn)); // R6

  AST_CNT_CLEAR: assert property (@(posedge aClk) disable iff (!rstN)
    !aClrN |=> (cntA == '0)); // R7

  AST_CNT_LOAD: assert property (@(posedge aClk) disable iff (!rstN)
    (aClrN && !aAdrLdN) |=> (cntA == $past(aAddr))); // R7

  AST_CNT_HOLD: assert property (@(posedge aClk) disable iff (!rstN)
    (aClrN && aAdrLdN && aAdvN) |=> $stable(cntA)); // R7

  AST_CNT_STEP: assert property (@(posedge aClk) disable iff (!rstN)
    (aClrN && aAdrLdN && !aAdvN) |=> (cntA == AW'($past(cntA) + AW'(1)))); // R10

  AST_RST_STATE: assert property (@(posedge aClk)
    !rstN |-> (!aDoutEn && cntA == '0)); // R9

endmodule

bind tdp_sync_ram tdp_sync_ram_chk #(.AW(AW)) u_chk (
  .rstN   (rstN),
  .aClk   (aClk),
  .aCsN   (aCsN),
  .aCs    (aCs),
  .aRdWrN (aRdWrN),
  .aOeN   (aOeN),
  .aPipe  (aPipe),
  .aAdrLdN(aAdrLdN),
  .aAdvN  (aAdvN),
  .aClrN  (aClrN),
  .aAddr  (aAddr),
  .aDoutEn(aDoutEn),
  .cntA   (cntQ[0]),
  .bClk   (bClk),
  .bCsN   (bCsN),
  .bCs    (bCs),
  .bOeN   (bOeN),
  .bDoutEn(bDoutEn)
);

// File: tb/tdp_sync_ram_tb.sv
`timescale 1ns/1ps
module tdp_sync_ram_tb;

  localparam int AW    = 8;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;

  logic          rstN;
  logic          clkA, clkB;
  logic          csN [2], cs [2], rdWrN [2], oeN [2], pipe [2];
  logic          ldN [2], advN [2], clrN [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] din [2];
  logic [DW-1:0] dout [2];
  logic          doutEn [2];

  // bench model
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] mCnt [2];
  logic [DW-1:0] mRd [2], mPipeD [2];
  logic          mVldF [2], mVldP [2];

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;
  string phaseTag = "R9";

  tdp_sync_ram #(.AW(AW), .DW(DW)) u_dut (
    .rstN(rstN),
    .aClk(clkA), .aCsN(csN[0]), .aCs(cs[0]), .aRdWrN(rdWrN[0]), .aOeN(oeN[0]),
    .aPipe(pipe[0]), .aAdrLdN(ldN[0]), .aAdvN(advN[0]), .aClrN(clrN[0]),
    .aAddr(addr[0]), .aDin(din[0]), .aDout(dout[0]), .aDoutEn(doutEn[0]),
    .bClk(clkB), .bCsN(csN[1]), .bCs(cs[1]), .bRdWrN(rdWrN[1]), .bOeN(oeN[1]),
    .bPipe(pipe[1]), .bAdrLdN(ldN[1]), .bAdvN(advN[1]), .bClrN(clrN[1]),
    .bAddr(addr[1]), .bDin(din[1]), .bDout(dout[1]), .bDoutEn(doutEn[1])
  );

  initial begin
    clkA = 1'b0;
    forever #5 clkA = ~clkA;
  end

  initial begin
    clkB = 1'b0;
    #3;
    forever #5 clkB = ~clkB;
  end

  function automatic logic [AW-1:0] nextAddrF(input logic [AW-1:0] c, input logic [AW-1:0] a,
                                               input logic ld, input logic adv, input logic clr);
    if (!clr) return '0;
    if (!ld)  return a;
    if (!adv) return c + AW'(1);
    return c;
  endfunction

  task automatic edgeModel(input int p);
    logic          sel;
    logic [AW-1:0] na;
    if (!rstN) begin
      mCnt[p] = '0; mRd[p] = '0; mPipeD[p] = '0; mVldF[p] = 1'b0; mVldP[p] = 1'b0;
      return;
    end
    sel = !csN[p] && cs[p];
    na  = nextAddrF(mCnt[p], addr[p], ldN[p], advN[p], clrN[p]);
    mVldP[p]  = mVldF[p] && sel;
    if (mVldF[p]) mPipeD[p] = mRd[p];
    if (sel && !rdWrN[p]) mem[na] = din[p];
    if (sel && rdWrN[p])  mRd[p] = mem[na];
    mVldF[p] = sel && rdWrN[p];
    mCnt[p]  = na;
  endtask

  task automatic check(input int p);
    logic          expEn;
    logic [DW-1:0] expD;
    string         tg;
    expEn = !oeN[p] && (pipe[p] ? mVldP[p] : mVldF[p]);
    expD  = pipe[p] ? mPipeD[p] : mRd[p];
    tg    = oeN[p] ? "R3" : (pipe[p] ? "R6" : "R4");
    vectors++;
    if (doutEn[p] !== expEn) begin
      miscompares++;
      $display("FAIL %s/%s port%0d drive enable actual %0b expected %0b at %0t",
               phaseTag, tg, p, doutEn[p], expEn, $time);
    end
    if (expEn) begin
      tg = pipe[p] ? "R5" : "R4";
      vectors++;
      if (dout[p] !== expD) begin
        miscompares++;
        $display("FAIL %s/%s port%0d data actual %03h expected %03h at %0t",
                 phaseTag, tg, p, dout[p], expD, $time);
      end
    end
  endtask

  task automatic cycle();
    @(posedge clkA); #1; edgeModel(0); #1; check(0);
    @(posedge clkB); #1; edgeModel(1); #1; check(1);
  endtask

  task automatic idle(input int p);
    csN[p] = 1'b1; cs[p] = 1'b0; rdWrN[p] = 1'b1; oeN[p] = 1'b0;
    ldN[p] = 1'b1; advN[p] = 1'b1; clrN[p] = 1'b1;
  endtask

  // selected access: ld=1 loads addr a, else advance when adv=1, else hold
  task automatic acc(input int p, input logic wr, input logic ld, input logic adv,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    csN[p] = 1'b0; cs[p] = 1'b1; rdWrN[p] = !wr; clrN[p] = 1'b1;
    ldN[p] = !ld; advN[p] = !adv; addr[p] = a; din[p] = d;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired at %0t", $time);
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b1;
    for (int p = 0; p < 2; p++) begin
      idle(p); pipe[p] = 1'b0; addr[p] = '0; din[p] = '0;
    end
    #1 rstN = 1'b0;
    // R9: reset state
    phaseTag = "R9";
    repeat (3) cycle();
    rstN = 1'b1;

    // R2 / R7: prefill every word from port A using load then advance
    phaseTag = "R2";
    for (int i = 0; i < DEPTH; i++) begin
      acc(0, 1'b1, i == 0, i != 0, '0, DW'($urandom));
      cycle();
    end
    idle(0);
    cycle();

    // R7: load, advance, hold, clear on port B, flow-through reads
    phaseTag = "R7";
    acc(1, 1'b0, 1'b1, 1'b0, AW'(20), '0); cycle();
    acc(1, 1'b0, 1'b0, 1'b1, '0, '0);      cycle();
    acc(1, 1'b0, 1'b0, 1'b0, '0, '0);      cycle();
    acc(1, 1'b0, 1'b0, 1'b0, '0, '0); clrN[1] = 1'b0; cycle();
    // clear coinciding with a write: word 0 receives it
    acc(1, 1'b1, 1'b0, 1'b1, '0, 9'h0C3); clrN[1] = 1'b0; cycle();
    acc(1, 1'b0, 1'b0, 1'b0, '0, '0);      cycle();

    // R10: wrap from the top word to word 0
    phaseTag = "R10";
    acc(1, 1'b0, 1'b1, 1'b0, AW'(DEPTH - 1), '0); cycle();
    acc(1, 1'b0, 1'b0, 1'b1, '0, '0);             cycle();
    idle(1); cycle();

    // R8: A writes, B reads same word at its next edge; then the reverse
    phaseTag = "R8";
    acc(0, 1'b1, 1'b1, 1'b0, AW'(5), 9'h1A5);
    acc(1, 1'b0, 1'b1, 1'b0, AW'(5), '0);
    cycle();
    acc(0, 1'b0, 1'b1, 1'b0, AW'(6), '0);
    acc(1, 1'b1, 1'b1, 1'b0, AW'(6), 9'h05A);
    cycle();
    acc(0, 1'b0, 1'b1, 1'b0, AW'(6), '0);
    acc(1, 1'b0, 1'b1, 1'b0, AW'(6), '0);
    cycle();
    idle(0); idle(1); cycle();

    // R1: write attempts while deselected leave the word unchanged
    phaseTag = "R1";
    acc(0, 1'b1, 1'b1, 1'b0, AW'(7), 9'h1FF); cs[0] = 1'b0; cycle();
    acc(0, 1'b1, 1'b1, 1'b0, AW'(7), 9'h100); csN[0] = 1'b1; cycle();
    acc(0, 1'b0, 1'b1, 1'b0, AW'(7), '0); cycle();
    idle(0); cycle();

    // R6 / R5: pipelined needs two selected edges
    phaseTag = "R6";
    pipe[0] = 1'b1;
    acc(0, 1'b0, 1'b1, 1'b0, AW'(3), '0); cycle();
    idle(0); cycle();
    cycle();
    acc(0, 1'b0, 1'b1, 1'b0, AW'(4), '0); cycle();
    acc(0, 1'b1, 1'b1, 1'b0, AW'(9), 9'h011); cycle();
    idle(0); cycle();
    // R3: output enable high blocks a pending read
    phaseTag = "R3";
    pipe[0] = 1'b0;
    acc(0, 1'b0, 1'b1, 1'b0, AW'(9), '0); cycle();
    oeN[0] = 1'b1; #1; check(0);
    oeN[0] = 1'b0; #1; check(0);
    idle(0); cycle();

    // R9: second reset pulse, then a hold access reaches word 0
    phaseTag = "R9";
    rstN = 1'b0; cycle(); rstN = 1'b1;
    acc(1, 1'b0, 1'b0, 1'b0, AW'(77), '0); cycle();
    idle(1); cycle();

    // random traffic on both ports
    phaseTag = "RND";
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < 2; p++) begin
        csN[p]   = ($urandom % 8) == 0;
        cs[p]    = ($urandom % 10) != 0;
        rdWrN[p] = 1'($urandom % 2);
        oeN[p]   = ($urandom % 10) == 0;
        if (($urandom % 20) == 0) pipe[p] = ~pipe[p];
        clrN[p]  = ($urandom % 32) != 0;
        ldN[p]   = ($urandom % 5) >= 2;
        advN[p]  = 1'($urandom % 2);
        addr[p]  = AW'($urandom);
        din[p]   = DW'($urandom);
      end
      cycle();
    end

    done = 1;
    report();
    $finish;
  end

endmodule